// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs one 16-byte read from a synchronous DRAM and closes the row with auto-precharge. A request carries a bank, a row and a column. Three small configuration fields come with it: the activate-to-read spacing, the read latency and the row-close wait. A fourth input selects a 32-bit or a 16-bit data bus. The block latches all of these when it accepts the request. It then drives the chip-select, row-strobe, column-strobe, write-enable, byte-mask and address pins through the whole access.

An access runs through these cycles in order:
- one activate cycle;
- optional spacing cycles;
- one read command cycle with the auto-precharge address bit set;
- optional latency wait cycles;
- the data capture cycles;
- one data-end cycle;
- a row-close wait.

Each captured word appears on `dataOut` with a one-cycle `dataValid` strobe. A transfer-acknowledge strobe marks the last word, and `done` marks the final cycle of the access. The latency field accepts a delay of up to four clocks, one more than the memory itself offers, so that register stages can sit between the memory and this block.

Top module: `sdram_burst_reader`

## Requirements
- R1: A request is accepted when `reqValid` is high and `busy` is low. In the next cycle the block issues an activate command (`memCsN`,`memRasN`,`memCasN`,`memWeN` = 0,0,1,1). During that cycle `memAddr` carries the row, zero-extended, and `memBank` carries the bank.
- R2: The read command (0,1,0,1) follows the activate by `cfgRcd`+1 clocks, on the same bank. A no-operation command (0,1,1,1) fills every cycle between the two.
- R3: During the read command, `memAddr[10]` is 1 and the low `COL_W` bits carry the column. All other address bits are 0.
- R4: The read latency is `cfgCasLat`+1 clocks, and all four values (1 to 4) are accepted. The first data capture cycle comes that many clocks after the read command, and no-operation commands fill the gap.
- R5: The block captures `memDq` in 4 consecutive cycles when `cfgWide`=1 and in 8 when `cfgWide`=0. In 16-bit mode it keeps `memDq[15:0]` and zero-extends it. Each word appears on `dataOut` with `dataValid` high in the cycle after its capture, in the order captured.
- R6: One data-end cycle follows the last capture, and then a row-close wait. With a wait field value P, the wait lasts P+1 cycles when the latency is 1 and P cycles when the latency is 2 or more. Both the data-end cycle and the row-close wait issue only no-operation commands.
- R7: `busy` is high from the activate cycle through the last row-close cycle, or through the data-end cycle when the wait is zero. `done` is high for exactly that final cycle.
- R8: `xferAck` is high for one cycle only, the one in which the last word is valid.
- R9: A request that arrives while `busy` is high is ignored: no extra activate is issued and the running access keeps its timing.
- R10: `memDqm` is 4'b1111 except from the read command cycle through the last capture cycle. In that window it is 4'b0000 in 32-bit mode and 4'b1100 in 16-bit mode.
- R11: After reset and whenever idle, `busy`, `done`, `dataValid` and `xferAck` are low, and all four command pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start request |
| reqBank | input | BANK_W | Bank to read |
| reqRow | input | ROW_W | Row to open |
| reqCol | input | COL_W | Start column |
| cfgRcd | input | 2 | Activate-to-read spacing minus one |
| cfgCasLat | input | 2 | Read latency minus one |
| cfgTrp | input | 2 | Row-close wait field |
| cfgWide | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqm | output | DATA_W/8 | Byte masks, high = masked |
| memAddr | output | ADDR_W | Multiplexed address |
| memBank | output | BANK_W | Bank select |
| memDq | input | DATA_W | Read data from memory |
| dataOut | output | DATA_W | Captured word |
| dataValid | output | 1 | `dataOut` holds a new word |
| xferAck | output | 1 | Last word of the transfer |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |

## Verification
The bench drives a memory model that places each data beat exactly one latency after the read command it observes. A design that captures one cycle early or late therefore returns visibly wrong words. The tests cover every latency value, including 4, the value beyond what the memory offers. They also hit both ends of the row-close wait: a latency-1 access stretches the wait to P+1 cycles, and a latency-2 access with P=0 removes the wait, so `done` has to fall on the data-end cycle. The 16-bit case checks the eight-beat count, the zero-extended upper half and the upper-lane masking. A request raised in the middle of an access has to leave the command trace untouched; a design that re-arms would show a second activate.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_ACT   = 2'd2,
    CMD_READ  = 2'd3
  } memCmd_e;

  typedef struct packed {
    memCmd_e cmd;
    logic    latchReq;
    logic    rowPhase;
    logic    colPhase;
    logic    capture;
    logic    lastBeat;
    logic    maskOn;
    logic    wide;
  } dpStrobe_t;

endpackage

// File: rtl/sdrb_ctrl.sv
module sdrb_ctrl
  import sdrb_pkg::*;
#(
  parameter int BURST_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] cfgRcd,
  input  logic [1:0] cfgCasLat,
  input  logic [1:0] cfgTrp,
  input  logic       cfgWide,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  localparam int BEATS_WIDE   = BURST_BYTES / 4;
  localparam int BEATS_NARROW = BURST_BYTES / 2;
  localparam int CNT_W        = $clog2(BEATS_NARROW) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCDW, ST_RD, ST_CLW, ST_DATA, ST_DEND, ST_PRE
  } state_e;

  state_e          state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]      rcdQ, clQ, trpQ;
  logic            wideQ;
  logic [2:0]      tapLen;
  logic [CNT_W-1:0] beatsLast;

  assign tapLen    = (clQ == 2'd0) ? ({1'b0, trpQ} + 3'd1) : {1'b0, trpQ};
  assign beatsLast = wideQ ? CNT_W'(BEATS_WIDE - 1) : CNT_W'(BEATS_NARROW - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rcdQ  <= '0;
      clQ   <= '0;
      trpQ  <= '0;
      wideQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_ACT;
          rcdQ  <= cfgRcd;
          clQ   <= cfgCasLat;
          trpQ  <= cfgTrp;
          wideQ <= cfgWide;
        end
        ST_ACT: if (rcdQ == 2'd0) state <= ST_RD;
                else begin
                  state <= ST_RCDW;
                  cnt   <= CNT_W'(rcdQ) - CNT_W'(1);
                end
        ST_RCDW: if (cnt == '0) state <= ST_RD;
                 else cnt <= cnt - CNT_W'(1);
        ST_RD: if (clQ == 2'd0) begin
                 state <= ST_DATA;
                 cnt   <= beatsLast;
               end else begin
                 state <= ST_CLW;
                 cnt   <= CNT_W'(clQ) - CNT_W'(1);
               end
        ST_CLW: if (cnt == '0) begin
                  state <= ST_DATA;
                  cnt   <= beatsLast;
                end else cnt <= cnt - CNT_W'(1);
        ST_DATA: if (cnt == '0) state <= ST_DEND;
                 else cnt <= cnt - CNT_W'(1);
        ST_DEND: if (tapLen == 3'd0) state <= ST_IDLE;
                 else begin
                   state <= ST_PRE;
                   cnt   <= CNT_W'(tapLen) - CNT_W'(1);
                 end
        ST_PRE: if (cnt == '0) state <= ST_IDLE;
                else cnt <= cnt - CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.cmd      = CMD_DESEL;
    strobe.wide     = wideQ;
    strobe.latchReq = (state == ST_IDLE) && reqValid;
    unique case (state)
      ST_IDLE: strobe.cmd = CMD_DESEL;
      ST_ACT: begin
        strobe.cmd      = CMD_ACT;
        strobe.rowPhase = 1'b1;
      end
      ST_RD: begin
        strobe.cmd      = CMD_READ;
        strobe.colPhase = 1'b1;
        strobe.maskOn   = 1'b1;
      end
      ST_CLW: begin
        strobe.cmd    = CMD_NOP;
        strobe.maskOn = 1'b1;
      end
      ST_DATA: begin
        strobe.cmd      = CMD_NOP;
        strobe.maskOn   = 1'b1;
        strobe.capture  = 1'b1;
        strobe.lastBeat = (cnt == '0);
      end
      default: strobe.cmd = CMD_NOP;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = ((state == ST_PRE) && (cnt == '0)) ||
                ((state == ST_DEND) && (tapLen == 3'd0));

  // R7: the final-cycle pulse only occurs inside an access
  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R7: the access is over right after the final-cycle pulse
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R5: captures stop before the data-end cycle
  p_last_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && strobe.lastBeat) |=> (busy && !strobe.capture));

endmodule

// File: rtl/sdrb_datapath.sv
module sdrb_datapath
  import sdrb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] memDq,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [DATA_W/8-1:0] memDqm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BANK_W-1:0] memBank,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid,
  output logic              xferAck
);
  localparam int LANES = DATA_W / 8;
  localparam int HALF  = DATA_W / 2;
  localparam logic [LANES-1:0] MASK_NARROW = {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};

  logic [BANK_W-1:0] bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [DATA_W-1:0] laneData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
    end else if (strobe.latchReq) begin
      bankQ <= reqBank;
      rowQ  <= reqRow;
      colQ  <= reqCol;
    end
  end

  always_comb begin
    {memCsN, memRasN, memCasN, memWeN} = 4'b1111;
    unique case (strobe.cmd)
      CMD_NOP:  {memCsN, memRasN, memCasN, memWeN} = 4'b0111;
      CMD_ACT:  {memCsN, memRasN, memCasN, memWeN} = 4'b0011;
      CMD_READ: {memCsN, memRasN, memCasN, memWeN} = 4'b0101;
      default:  {memCsN, memRasN, memCasN, memWeN} = 4'b1111;
    endcase
  end

  always_comb begin
    memAddr = '0;
    if (strobe.rowPhase) memAddr = ADDR_W'(rowQ);
    else if (strobe.colPhase) memAddr = ADDR_W'(colQ) | (ADDR_W'(1) << AP_BIT);
  end

  assign memBank  = bankQ;
  assign memDqm   = !strobe.maskOn ? '1 : (strobe.wide ? '0 : MASK_NARROW);
  assign laneData = strobe.wide ? memDq : {{(DATA_W-HALF){1'b0}}, memDq[HALF-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      xferAck   <= 1'b0;
    end else begin
      dataValid <= strobe.capture;
      xferAck   <= strobe.capture && strobe.lastBeat;
      if (strobe.capture) dataOut <= laneData;
    end
  end

  // R8: the acknowledge strobe rides on a valid word
  p_ack_with_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> dataValid);
  // R3: the read command carries the auto-precharge bit
  p_a10_on_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && memRasN && !memCasN) |-> memAddr[AP_BIT]);
  // R2: an activate is never followed at once by another activate
  p_single_act_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !memRasN && memCasN) |=> !(!memCsN && !memRasN && memCasN));

endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
  import sdrb_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 32,
  parameter int BURST_BYTES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  input  logic [1:0]          cfgRcd,
  input  logic [1:0]          cfgCasLat,
  input  logic [1:0]          cfgTrp,
  input  logic                cfgWide,
  output logic                memCsN,
  output logic                memRasN,
  output logic                memCasN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memDqm,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BANK_W-1:0]   memBank,
  input  logic [DATA_W-1:0]   memDq,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataValid,
  output logic                xferAck,
  output logic                busy,
  output logic                done
);
  dpStrobe_t strobe;

  sdrb_ctrl #(.BURST_BYTES(BURST_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgRcd(cfgRcd), .cfgCasLat(cfgCasLat), .cfgTrp(cfgTrp), .cfgWide(cfgWide),
    .strobe(strobe), .busy(busy), .done(done)
  );

  sdrb_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AP_BIT(10)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .memDq(memDq),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memDqm(memDqm), .memAddr(memAddr), .memBank(memBank),
    .dataOut(dataOut), .dataValid(dataValid), .xferAck(xferAck)
  );

  // R11: the chip is deselected whenever no access runs
  p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> memCsN);
  // R9: an activate only appears in the first cycle of an access
  p_act_after_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !memRasN && memCasN) |-> !$past(busy));

endmodule

// File: tb/sdram_burst_reader_tb_top.sv
module sdram_burst_reader_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [8:0]  reqCol = '0;
  logic [1:0]  cfgRcd = '0, cfgCasLat = '0, cfgTrp = '0;
  logic        cfgWide = 1'b1;
  logic        memCsN, memRasN, memCasN, memWeN;
  logic [3:0]  memDqm;
  logic [12:0] memAddr;
  logic [1:0]  memBank;
  logic [31:0] memDq = '0;
  logic [31:0] dataOut;
  logic        dataValid, xferAck, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sdram_burst_reader dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .cfgRcd(cfgRcd), .cfgCasLat(cfgCasLat),
    .cfgTrp(cfgTrp), .cfgWide(cfgWide), .memCsN(memCsN), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memDqm(memDqm), .memAddr(memAddr),
    .memBank(memBank), .memDq(memDq), .dataOut(dataOut), .dataValid(dataValid),
    .xferAck(xferAck), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] beatPat(input int k);
    return {8'hA0 + 8'(k), 8'h5A, 8'h3C ^ 8'(k), 8'h10 + 8'(k)};
  endfunction

  // One access: rcdF/clF/trpF are field values; strayAt>0 raises a request mid-access
  task automatic runBurst(input int rcdF, input int clF, input int trpF, input bit wide,
                          input logic [1:0] bank, input logic [12:0] row,
                          input logic [8:0] col, input int strayAt);
    int cl = clF + 1;
    int nb = wide ? 4 : 8;
    int tRd = rcdF + 1;
    int firstCap = tRd + cl;
    int tDend = firstCap + nb;
    int tap = (clF == 0) ? trpF + 1 : trpF;
    int last = tDend + tap;
    int tRdSeen = -1;
    int acts = 0;
    int words = 0;
    logic [3:0] expCmd, actCmd;
    string tag;
    @(negedge clk);
    reqValid = 1'b1; reqBank = bank; reqRow = row; reqCol = col;
    cfgRcd = 2'(rcdF); cfgCasLat = 2'(clF); cfgTrp = 2'(trpF); cfgWide = wide;
    @(negedge clk);
    reqValid = 1'b0;
    cfgRcd = 2'd3; cfgCasLat = 2'd3; cfgTrp = 2'd3; cfgWide = ~wide;
    for (int t = 0; t < 32; t++) begin
      actCmd = {memCsN, memRasN, memCasN, memWeN};
      if (t == 0) begin expCmd = 4'b0011; tag = "R1"; end
      else if (t < tRd) begin expCmd = 4'b0111; tag = "R2"; end
      else if (t == tRd) begin expCmd = 4'b0101; tag = "R2"; end
      else if (t < firstCap) begin expCmd = 4'b0111; tag = "R4"; end
      else if (t < tDend) begin expCmd = 4'b0111; tag = "R5"; end
      else if (t <= last) begin expCmd = 4'b0111; tag = "R6"; end
      else begin expCmd = 4'b1111; tag = "R11"; end
      check(actCmd == expCmd, tag, actCmd, expCmd);
      if (actCmd == 4'b0011) acts++;
      if (actCmd == 4'b0101 && tRdSeen < 0) tRdSeen = t;
      if (t == 0) begin
        check(memAddr == 13'(row), "R1 row address", memAddr, 13'(row));
        check(memBank == bank, "R1 bank", memBank, bank);
      end
      if (t == tRd) begin
        check(memAddr == (13'(col) | 13'h400), "R3 column address", memAddr, 13'(col) | 13'h400);
        check(memBank == bank, "R2 bank", memBank, bank);
      end
      check(memDqm == ((t >= tRd && t < tDend) ? (wide ? 4'b0000 : 4'b1100) : 4'b1111),
            "R10 dqm", memDqm, (t >= tRd && t < tDend) ? (wide ? 4'b0000 : 4'b1100) : 4'b1111);
      check(busy == (t <= last), "R7 busy", busy, t <= last);
      check(done == (t == last), "R7 done", done, t == last);
      check(xferAck == (t == tDend), "R8 ack", xferAck, t == tDend);
      check(dataValid == (t > firstCap && t <= tDend), "R5 valid", dataValid,
            t > firstCap && t <= tDend);
      if (dataValid && t > firstCap && t <= tDend) begin
        logic [31:0] expW = beatPat(t - firstCap - 1);
        if (!wide) expW = {16'h0, expW[15:0]};
        check(dataOut == expW, "R5 data", dataOut, expW);
        words++;
      end
      // memory model: beat k sits on the bus cl clocks after the read it saw
      if (tRdSeen >= 0 && t - tRdSeen - cl >= 0 && t - tRdSeen - cl < nb)
        memDq = beatPat(t - tRdSeen - cl);
      else
        memDq = 32'hFFFF_EEEE;
      if (strayAt > 0 && t == strayAt) begin reqValid = 1'b1; reqRow = ~row; end
      if (strayAt > 0 && t == strayAt + 1) reqValid = 1'b0;
      @(negedge clk);
    end
    check(acts == 1, "R9 single activate", acts, 1);
    check(words == nb, "R5 word count", words, nb);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check({memCsN, memRasN, memCasN, memWeN} == 4'b1111, "R11 reset pins",
          {memCsN, memRasN, memCasN, memWeN}, 4'b1111);
    check({busy, done, dataValid, xferAck} == 4'b0, "R11 reset flags",
          {busy, done, dataValid, xferAck}, 0);
    check(memDqm == 4'b1111, "R10 reset dqm", memDqm, 4'b1111);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // R4 latency 1 and R6 stretched wait (P+1)
  task automatic testWideCl1();
    runBurst(0, 0, 1, 1'b1, 2'd1, 13'h1ABC, 9'h155, 0);
    runBurst(1, 0, 3, 1'b1, 2'd0, 13'h0F0F, 9'h001, 0);
  endtask

  // R5 eight beats and R6 zero wait with latency 2
  task automatic testNarrowNoWait();
    runBurst(2, 1, 0, 1'b0, 2'd2, 13'h0777, 9'h0AA, 0);
  endtask

  // R4 latency 4 beyond the memory's own limit
  task automatic testWideCl4();
    runBurst(3, 3, 3, 1'b1, 2'd3, 13'h1FFF, 9'h1FF, 0);
  endtask

  // R9 stray request during an access
  task automatic testStrayRequest();
    runBurst(1, 2, 2, 1'b0, 2'd1, 13'h0123, 9'h0C3, 3);
  endtask

  initial begin
    testReset();
    testWideCl1();
    testNarrowNoWait();
    testWideCl4();
    testStrayRequest();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule